// File: doc/BRIEF.md
# Strap-Selected Boot Source Sequencer

This block decides, right after reset, where the processor's first program comes from. It samples three strap pins once, on the first clock after reset is released, and selects one of three behaviours: a normal load from external serial flash, a wait for an external programmer to send commands, or a debug stop that keeps the core halted. Any other strap pattern is treated as a board fault and also halts the core.

In the normal-load behaviour the sequencer first asks a flash protocol engine (outside this block) to run a discovery query. A valid answer sends it through a fixed walk of image slots, one slot read request at a time, until a slot passes its integrity check; the read width follows the richest mode the flash advertises. An invalid answer sends it to a host-driven SPI download path instead. A good slot or a finished SPI download ends in a one-cycle handoff pulse carrying the chosen slot index. If every slot is bad, a sticky failure flag is raised and the sequencer stops issuing requests. While the flash path is active it also produces a flash clock enable at one system cycle in DIV.

Top module: `boot_seq_top`

## Requirements
- R1: The strap inputs are captured on the first rising clock edge after rst_n goes high; later strap changes do not alter mode_o or any other output.
- R2: Strap code {strap_i[2],strap_i[1],strap_i[0]} = 001 gives mode_o = 0 (flash load), 101 gives mode_o = 1 (host_wait_o high), 011 gives mode_o = 2 (halt_o high).
- R3: Every other strap code gives mode_o = 3 with strap_err_o and halt_o both high, and no probe, slot or SPI request ever.
- R4: In flash-load mode probe_req_o is high from the cycle after the strap capture until probe_done_i is seen; no slot or SPI request comes before it.
- R5: When probe_done_i arrives with probe_valid_i low, spi_dl_o goes high in the next cycle and no slot request is ever made; spi_dl_o is never raised after a valid probe.
- R6: After a valid probe, slot_req_o is high and slot_addr_o walks 0x000000, 0x080000, 0x100000, 0x180000, advancing one slot for each slot_done_i with slot_ok_i low.
- R7: On a valid probe, read_width_o latches 2 (quad) if probe_caps_i[1] is set, else 1 (dual) if probe_caps_i[0] is set, else 0 (single).
- R8: While a probe or slot read is pending, fclk_en_o pulses high for one cycle in every 5, the first pulse in the fifth cycle of the active period; it stays low otherwise.
- R9: When the fourth slot also fails, boot_fail_o goes high the next cycle and stays high, with no further requests or handoff.
- R10: A slot_done_i with slot_ok_i high, or spi_done_i in SPI mode, gives handoff_o high for exactly one cycle in the next cycle, with boot_slot_o holding the passing slot index (0 for the SPI path).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| strap_i | input | 3 | Boot strap pins |
| probe_done_i | input | 1 | Discovery query finished |
| probe_valid_i | input | 1 | Discovery answer was valid |
| probe_caps_i | input | 2 | Advertised widths: bit1 quad, bit0 dual |
| slot_done_i | input | 1 | Slot read and check finished |
| slot_ok_i | input | 1 | Slot passed its integrity check |
| spi_done_i | input | 1 | Host SPI download finished |
| mode_o | output | 2 | Selected boot mode |
| probe_req_o | output | 1 | Request discovery query |
| slot_req_o | output | 1 | Request read of current slot |
| slot_addr_o | output | 24 | Base address of current slot |
| read_width_o | output | 2 | Flash read width code |
| fclk_en_o | output | 1 | Flash clock enable |
| spi_dl_o | output | 1 | SPI download path active |
| host_wait_o | output | 1 | Waiting for programmer commands |
| halt_o | output | 1 | Hold the core halted |
| strap_err_o | output | 1 | Unknown strap code |
| handoff_o | output | 1 | One-cycle boot handoff pulse |
| boot_slot_o | output | 2 | Slot index of the handoff |
| boot_fail_o | output | 1 | All slots failed |

## Verification
On every cycle the assertions check that the mode stays frozen after capture, that the handoff is a single-cycle pulse never paired with the failure flag, that the failure flag is sticky, that the SPI path is entered only right after an invalid probe, that a pending slot address does not move, and that the clock enable never lasts two cycles. Only the bench's scenarios show the exact strap-to-mode mapping, the slot address sequence for every count of failing slots, the width choice for every capability pattern, and the five-cycle spacing of the clock enable.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [1:0] {
        MODE_FLASH = 2'd0,
        MODE_HOST  = 2'd1,
        MODE_DEBUG = 2'd2,
        MODE_BAD   = 2'd3
    } boot_mode_t;

    typedef enum logic [3:0] {
        ST_START,
        ST_PROBE,
        ST_SLOT,
        ST_SPI,
        ST_HOST,
        ST_DEBUG,
        ST_ERROR,
        ST_DONE,
        ST_FAIL
    } seq_state_t;

    localparam logic [1:0] WIDTH_SINGLE = 2'd0;
    localparam logic [1:0] WIDTH_DUAL   = 2'd1;
    localparam logic [1:0] WIDTH_QUAD   = 2'd2;

endpackage

// File: rtl/boot_strap_dec.sv
module boot_strap_dec
    import boot_seq_pkg::*;
(
    input  logic [2:0]  strap_i,
    output boot_mode_t  mode_o
);
    always_comb begin
        unique case (strap_i)
            3'b001:  mode_o = MODE_FLASH;
            3'b101:  mode_o = MODE_HOST;
            3'b011:  mode_o = MODE_DEBUG;
            default: mode_o = MODE_BAD;
        endcase
    end
endmodule

// File: rtl/boot_clk_div.sv
module boot_clk_div #(
    parameter int DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i)            cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = run_i && (cnt_q == LAST);

    // R8: enable is a single-cycle pulse
    a_r8_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
    import boot_seq_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int NUM_SLOTS   = 4,
    parameter int SLOT_STRIDE = 32'h0008_0000,
    parameter int FCLK_DIV    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        strap_i,
    input  logic              probe_done_i,
    input  logic              probe_valid_i,
    input  logic [1:0]        probe_caps_i,
    input  logic              slot_done_i,
    input  logic              slot_ok_i,
    input  logic              spi_done_i,
    output logic [1:0]        mode_o,
    output logic              probe_req_o,
    output logic              slot_req_o,
    output logic [ADDR_W-1:0] slot_addr_o,
    output logic [1:0]        read_width_o,
    output logic              fclk_en_o,
    output logic              spi_dl_o,
    output logic              host_wait_o,
    output logic              halt_o,
    output logic              strap_err_o,
    output logic              handoff_o,
    output logic [1:0]        boot_slot_o,
    output logic              boot_fail_o
);
    localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam logic [SW-1:0] LAST_SLOT = SW'(NUM_SLOTS - 1);

    typedef struct packed {
        seq_state_t  st;
        boot_mode_t  mode;
        logic [SW-1:0] slot;
        logic [1:0]  width;
        logic        handoff;
    } seq_reg_t;

    seq_reg_t   r_d, r_q;
    boot_mode_t strap_mode;
    logic       flash_run;

    boot_strap_dec u_dec (
        .strap_i (strap_i),
        .mode_o  (strap_mode)
    );

    assign flash_run = (r_q.st == ST_PROBE) || (r_q.st == ST_SLOT);

    boot_clk_div #(.DIV(FCLK_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (flash_run),
        .tick_o (fclk_en_o)
    );

    always_comb begin
        r_d         = r_q;
        r_d.handoff = 1'b0;
        unique case (r_q.st)
            ST_START: begin
                r_d.mode = strap_mode;
                unique case (strap_mode)
                    MODE_FLASH: r_d.st = ST_PROBE;
                    MODE_HOST:  r_d.st = ST_HOST;
                    MODE_DEBUG: r_d.st = ST_DEBUG;
                    default:    r_d.st = ST_ERROR;
                endcase
            end
            ST_PROBE: begin
                if (probe_done_i) begin
                    if (probe_valid_i) begin
                        r_d.st    = ST_SLOT;
                        r_d.slot  = '0;
                        if (probe_caps_i[1])      r_d.width = WIDTH_QUAD;
                        else if (probe_caps_i[0]) r_d.width = WIDTH_DUAL;
                        else                      r_d.width = WIDTH_SINGLE;
                    end else begin
                        r_d.st = ST_SPI;
                    end
                end
            end
            ST_SLOT: begin
                if (slot_done_i) begin
                    if (slot_ok_i) begin
                        r_d.st      = ST_DONE;
                        r_d.handoff = 1'b1;
                    end else if (r_q.slot == LAST_SLOT) begin
                        r_d.st = ST_FAIL;
                    end else begin
                        r_d.slot = r_q.slot + 1'b1;
                    end
                end
            end
            ST_SPI: begin
                if (spi_done_i) begin
                    r_d.st      = ST_DONE;
                    r_d.handoff = 1'b1;
                    r_d.slot    = '0;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_START, mode: MODE_FLASH, slot: '0,
                     width: WIDTH_SINGLE, handoff: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mode_o       = r_q.mode;
    assign probe_req_o  = (r_q.st == ST_PROBE);
    assign slot_req_o   = (r_q.st == ST_SLOT);
    assign slot_addr_o  = ADDR_W'(r_q.slot) * ADDR_W'(SLOT_STRIDE);
    assign read_width_o = r_q.width;
    assign spi_dl_o     = (r_q.st == ST_SPI);
    assign host_wait_o  = (r_q.st == ST_HOST);
    assign halt_o       = (r_q.st == ST_DEBUG) || (r_q.st == ST_ERROR);
    assign strap_err_o  = (r_q.st == ST_ERROR);
    assign handoff_o    = r_q.handoff;
    assign boot_slot_o  = 2'(r_q.slot);
    assign boot_fail_o  = (r_q.st == ST_FAIL);

    // R1: mode frozen once captured
    a_r1_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_START) |=> $stable(mode_o));
    // R5: SPI path only right after an invalid probe answer
    a_r5_spi_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_dl_o) |-> $past(probe_req_o && probe_done_i && !probe_valid_i));
    // R6: slot address holds while a read is pending
    a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req_o && !slot_done_i) |=> $stable(slot_addr_o));
    // R9: failure is sticky and silent
    a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        boot_fail_o |=> (boot_fail_o && !slot_req_o && !probe_req_o));
    // R10: handoff is a single pulse, never with failure
    a_r10_handoff_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        handoff_o |=> !handoff_o);
    a_r10_handoff_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(handoff_o && boot_fail_o));
    // R3: error and requests never together
    a_r3_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        strap_err_o |-> (halt_o && !probe_req_o && !slot_req_o && !spi_dl_o));
endmodule

// File: tb/boot_seq_top_tb.sv
module boot_seq_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  strap_i = '0;
    logic        probe_done_i = 1'b0, probe_valid_i = 1'b0;
    logic [1:0]  probe_caps_i = '0;
    logic        slot_done_i = 1'b0, slot_ok_i = 1'b0, spi_done_i = 1'b0;
    logic [1:0]  mode_o, read_width_o, boot_slot_o;
    logic        probe_req_o, slot_req_o, fclk_en_o, spi_dl_o, host_wait_o;
    logic        halt_o, strap_err_o, handoff_o, boot_fail_o;
    logic [23:0] slot_addr_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    boot_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i),
        .probe_done_i(probe_done_i), .probe_valid_i(probe_valid_i),
        .probe_caps_i(probe_caps_i), .slot_done_i(slot_done_i),
        .slot_ok_i(slot_ok_i), .spi_done_i(spi_done_i),
        .mode_o(mode_o), .probe_req_o(probe_req_o), .slot_req_o(slot_req_o),
        .slot_addr_o(slot_addr_o), .read_width_o(read_width_o),
        .fclk_en_o(fclk_en_o), .spi_dl_o(spi_dl_o), .host_wait_o(host_wait_o),
        .halt_o(halt_o), .strap_err_o(strap_err_o), .handoff_o(handoff_o),
        .boot_slot_o(boot_slot_o), .boot_fail_o(boot_fail_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic start(input logic [2:0] s);
        rst_n = 1'b0;
        strap_i = s;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 reset handoff", handoff_o, 0);
        chk("R1 reset probe", probe_req_o, 0);
        rst_n = 1'b1;
        @(posedge clk);      // capture edge
        @(negedge clk);
        strap_i = ~s;        // must be ignored from here on
    endtask

    function automatic logic [1:0] exp_mode(input logic [2:0] s);
        case (s)
            3'b001:  return 2'd0;
            3'b101:  return 2'd1;
            3'b011:  return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    task automatic pulse_probe(input logic v, input logic [1:0] caps);
        probe_done_i = 1'b1; probe_valid_i = v; probe_caps_i = caps;
        @(negedge clk);
        probe_done_i = 1'b0; probe_valid_i = 1'b0;
    endtask

    // flash run: slots below k fail, slot k passes (k==4: all fail)
    task automatic flash_run(input int k, input logic [1:0] caps);
        logic [1:0] w;
        start(3'b001);
        chk("R2 mode flash", mode_o, 0);
        chk("R4 probe first", probe_req_o, 1);
        chk("R4 no slot early", slot_req_o, 0);
        pulse_probe(1'b1, caps);
        w = caps[1] ? 2'd2 : (caps[0] ? 2'd1 : 2'd0);
        chk("R7 width", read_width_o, w);
        chk("R5 no spi after valid", spi_dl_o, 0);
        for (int i = 0; i < 4; i++) begin
            chk("R6 slot req", slot_req_o, 1);
            chk("R6 slot addr", slot_addr_o, i * 32'h80000);
            slot_done_i = 1'b1; slot_ok_i = (i == k);
            @(negedge clk);
            slot_done_i = 1'b0; slot_ok_i = 1'b0;
            if (i == k) begin
                chk("R10 handoff", handoff_o, 1);
                chk("R10 slot idx", boot_slot_o, k);
                @(negedge clk);
                chk("R10 one cycle", handoff_o, 0);
                chk("R10 no req after", slot_req_o, 0);
                break;
            end
        end
        if (k >= 4) begin
            chk("R9 fail flag", boot_fail_o, 1);
            chk("R9 no handoff", handoff_o, 0);
            repeat (3) @(negedge clk);
            chk("R9 sticky", boot_fail_o, 1);
            chk("R9 silent", slot_req_o | probe_req_o, 0);
        end
        chk("R1 mode kept", mode_o, 0);
    endtask

    initial begin
        // R2/R3: exhaustive strap sweep
        for (int s = 0; s < 8; s++) begin
            logic [1:0] m;
            m = exp_mode(3'(s));
            start(3'(s));
            for (int c = 0; c < 4; c++) begin
                chk("R2 mode", mode_o, m);
                chk("R2 host wait", host_wait_o, m == 2'd1);
                chk("R2 halt", halt_o, m >= 2'd2);
                chk("R3 strap err", strap_err_o, m == 2'd3);
                if (m != 2'd0) chk("R3 no probe", probe_req_o | slot_req_o | spi_dl_o, 0);
                @(negedge clk);
            end
            chk("R1 ignored later", mode_o, m);
        end

        // R8: clock enable spacing during a long probe
        start(3'b001);
        for (int n = 0; n < 15; n++) begin
            chk("R8 fclk", fclk_en_o, (n % 5) == 4);
            @(negedge clk);
        end
        pulse_probe(1'b0, 2'b11);
        // R5: invalid probe goes to SPI path
        chk("R5 spi", spi_dl_o, 1);
        chk("R5 no slot", slot_req_o, 0);
        chk("R8 idle fclk", fclk_en_o, 0);
        repeat (3) @(negedge clk);
        chk("R5 spi hold", spi_dl_o, 1);
        spi_done_i = 1'b1;
        @(negedge clk);
        spi_done_i = 1'b0;
        chk("R10 spi handoff", handoff_o, 1);
        chk("R10 spi slot", boot_slot_o, 0);
        @(negedge clk);
        chk("R10 spi one cycle", handoff_o, 0);

        // R6/R7/R9/R10: every failing-slot count and every capability code
        for (int k = 0; k <= 4; k++)
            for (int c = 0; c < 4; c++)
                flash_run(k, 2'(c));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule